// File: doc/BRIEF.md
# SCSI Target Data-In Sequencer

This block is the target-side engine for the data-in phase of a SCSI bus. A host register port issues one of two opcodes. The first moves bytes from a data buffer (DMA form). The second moves bytes from a host-loaded FIFO (CPU form). While a command runs, the block drives the phase lines for data-in and places one byte at a time on the data bus. It paces each byte with a full REQ/ACK interlock against the initiator.

The block loads a remaining-byte counter from one of two length inputs, chosen by the form of the command. It holds the handshake while its byte source is not ready. For the DMA form, the source is ready when the go enable is high. For the CPU form, the source is ready when the FIFO is not empty. When the counter runs out, the block posts completion flags into a small interrupt register. It also posts an error flag when a command arrives while the bus is not connected.

Top module: `scsi_din_seq`

## Requirements
- R1: Opcode 0x15 starts a DMA transfer and opcode 0x16 starts a CPU transfer. The block ignores any other opcode, and any opcode that arrives while a transfer is running: no flag changes and busy stays as it was.
- R2: If opcode 0x15 or 0x16 arrives while `connected` is low, the block sets the error flag (flag bit 2) on the next clock. It starts no transfer and never raises REQ.
- R3: In DMA form, no byte is fetched and REQ stays low while `dma_go` is low. Transfer starts once `dma_go` is high.
- R4: When a DMA-form transfer sends its `dma_len`-th byte, the block sets both the GOOD flag (bit 0) and the DMA-done flag (bit 1), and busy drops.
- R5: In CPU form, the block drives the data-in phase (`bus_io` high, `bus_cd` and `bus_msg` low) from the cycle after the command onward. It then sends exactly `cpu_len` bytes, in FIFO order.
- R6: In CPU form, while the FIFO is empty the block pops nothing and REQ stays low. The handshake resumes when data arrives.
- R7: When a CPU-form transfer completes, the block sets only the GOOD flag (bit 0). The DMA-done flag stays clear.
- R8: Flags are sticky until the host writes 1 to the matching bit of `irq_clr`. `irq` is the OR of the flags that are enabled in `irq_en`.
- R9: A command with a zero length completes on the next clock with GOOD set (and DMA-done set too, in DMA form). It raises no REQ.
- R10: Each byte is valid on `bus_data` while REQ is high. REQ falls only after ACK has been seen high. The next REQ waits until ACK has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_op | input | 8 | Command opcode |
| connected | input | 1 | Bus is in the connected condition |
| dma_go | input | 1 | DMA go enable |
| dma_len | input | CNT_W | Byte count for the DMA form |
| cpu_len | input | CNT_W | Byte count for the CPU form |
| buf_data | input | DW | Next byte from the data buffer |
| buf_pop | output | 1 | Consume a buffer byte |
| fifo_data | input | DW | Head byte of the host FIFO |
| fifo_empty | input | 1 | Host FIFO empty |
| fifo_pop | output | 1 | Consume a FIFO byte |
| bus_io | output | 1 | Phase line I/O |
| bus_cd | output | 1 | Phase line C/D |
| bus_msg | output | 1 | Phase line MSG |
| bus_req | output | 1 | REQ to the initiator |
| bus_ack | input | 1 | ACK from the initiator |
| bus_data | output | DW | Data bus byte |
| bus_oe | output | 1 | Data bus drive enable |
| busy | output | 1 | A transfer is running |
| irq_en | input | 3 | Per-flag interrupt enable |
| irq_clr | input | 3 | Write-one-to-clear flags |
| irq_flags | output | 3 | Sticky flags: bit0 GOOD, bit1 DMA-done, bit2 error |
| irq | output | 1 | Interrupt request |

## Verification
An emulated initiator answers every REQ. A scoreboard compares each byte against the order that the driver queued. The DMA form is run twice, first with go held low and then with go raised, to separate the gating from the data path. The CPU form starts on an empty FIFO that is filled slowly, byte by byte, to show the stall and the exact byte count. Zero-length commands, a disconnected bus, a stray opcode and masked interrupt enables separate the flag sets of each completion path.

// File: rtl/scsi_din_seq.sv
module scsi_din_seq #(
  parameter int CNT_W = 16,
  parameter int DW = 8,
  parameter logic [7:0] OP_DMA = 8'h15,
  parameter logic [7:0] OP_CPU = 8'h16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_op,
  input  logic             connected,
  input  logic             dma_go,
  input  logic [CNT_W-1:0] dma_len,
  input  logic [CNT_W-1:0] cpu_len,
  input  logic [DW-1:0]    buf_data,
  output logic             buf_pop,
  input  logic [DW-1:0]    fifo_data,
  input  logic             fifo_empty,
  output logic             fifo_pop,
  output logic             bus_io,
  output logic             bus_cd,
  output logic             bus_msg,
  output logic             bus_req,
  input  logic             bus_ack,
  output logic [DW-1:0]    bus_data,
  output logic             bus_oe,
  output logic             busy,
  input  logic [2:0]       irq_en,
  input  logic [2:0]       irq_clr,
  output logic [2:0]       irq_flags,
  output logic             irq
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_REQ, S_REL} st_t;
  st_t st;
  logic use_dma;
  logic [CNT_W-1:0] remain;
  logic [DW-1:0] dreg;

  wire is_dma = (cmd_op == OP_DMA);
  wire op_hit = cmd_we && (is_dma || cmd_op == OP_CPU) && st == S_IDLE;
  wire [CNT_W-1:0] start_len = is_dma ? dma_len : cpu_len;
  wire src_ok = use_dma ? dma_go : !fifo_empty;
  wire load = (st == S_WAIT) && src_ok;
  wire last = (st == S_REL) && !bus_ack && remain == CNT_W'(1);
  wire zero_done = op_hit && connected && start_len == '0;
  wire set_err = op_hit && !connected;
  wire [2:0] set_vec = {set_err,
                        (zero_done && is_dma) || (last && use_dma),
                        zero_done || last};

  assign buf_pop  = load && use_dma;
  assign fifo_pop = load && !use_dma;
  assign busy     = (st != S_IDLE);
  assign bus_io   = busy;
  assign bus_cd   = 1'b0;
  assign bus_msg  = 1'b0;
  assign bus_oe   = busy;
  assign bus_req  = (st == S_REQ);
  assign bus_data = dreg;
  assign irq      = |(irq_flags & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      use_dma <= 1'b0;
      remain <= '0;
      dreg <= '0;
      irq_flags <= '0;
    end else begin
      irq_flags <= (irq_flags & ~irq_clr) | set_vec;
      case (st)
        S_IDLE: if (op_hit && connected && start_len != '0) begin
          st <= S_WAIT;
          use_dma <= is_dma;
          remain <= start_len;
        end
        S_WAIT: if (load) begin
          dreg <= use_dma ? buf_data : fifo_data;
          st <= S_REQ;
        end
        S_REQ: if (bus_ack) st <= S_REL;
        S_REL: if (!bus_ack) begin
          remain <= remain - CNT_W'(1);
          st <= last ? S_IDLE : S_WAIT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  req_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(bus_ack));
  // R10
  req_stable_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> $stable(bus_data));
  // R5
  req_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_io && !bus_cd && !bus_msg));
  // R6
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  // R3
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |-> dma_go);
  // R2
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flags[2]) |-> $past(cmd_we && !connected));
  // R4
  dma_done_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flags[1]) |-> irq_flags[0]);
endmodule

// File: tb/scsi_din_seq_tb.sv
module scsi_din_seq_tb_top;
  localparam int CNT_W = 16;
  logic clk = 0, rst_n = 0;
  logic cmd_we = 0, connected = 0, dma_go = 0, bus_ack = 0;
  logic [7:0] cmd_op = 0;
  logic [CNT_W-1:0] dma_len = 0, cpu_len = 0;
  logic [7:0] buf_data, fifo_data, bus_data;
  logic buf_pop, fifo_pop, fifo_empty, bus_io, bus_cd, bus_msg, bus_req, bus_oe, busy, irq;
  logic [2:0] irq_en = 0, irq_clr = 0, irq_flags;

  logic [7:0] fmem [256];
  logic [7:0] rd_idx = 0, wr_idx = 0, buf_idx = 0, dma_next = 0;
  logic [7:0] exp_q [$];
  int checks = 0, fails = 0, seen = 0, req_cnt = 0;

  always #2.5 clk = ~clk;

  assign fifo_empty = (rd_idx == wr_idx);
  assign fifo_data = fmem[rd_idx];
  assign buf_data = 8'hA0 + buf_idx;
  always @(posedge clk) begin
    if (fifo_pop) rd_idx <= rd_idx + 1;
    if (buf_pop) buf_idx <= buf_idx + 1;
  end

  scsi_din_seq #(.CNT_W(CNT_W)) dut_i (.*);

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // Monitor: emulated initiator, pops scoreboard on each REQ
  always @(negedge clk) begin
    if (bus_req && !bus_ack) begin
      req_cnt++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5: actual byte %0h expected none", bus_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        seen++;
        if (bus_data != e || !bus_io) begin
          fails++;
          $display("FAIL R10: actual %0h io %0b expected %0h io 1", bus_data, bus_io, e);
        end
      end
      bus_ack = 1;
    end else if (!bus_req && bus_ack) bus_ack = 0;
  end

  task automatic issue(input logic [7:0] op);
    @(negedge clk); cmd_op = op; cmd_we = 1;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic push_fifo(input logic [7:0] b);
    @(negedge clk); fmem[wr_idx] = b; wr_idx = wr_idx + 1; exp_q.push_back(b);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); irq_clr = 3'b111;
    @(negedge clk); irq_clr = 3'b000;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset flags", irq_flags, 0);
    chk("R10 reset req", bus_req, 0);
    chk("R5 reset busy", busy, 0);

    // R2 disconnected
    irq_en = 3'b111;
    issue(8'h15);
    chk("R2 err flag", irq_flags, 3'b100);
    chk("R2 no busy", busy, 0);
    chk("R8 irq on", irq, 1);
    irq_en = 3'b011;
    @(negedge clk);
    chk("R8 irq masked", irq, 0);
    clear_all();
    chk("R8 cleared", irq_flags, 0);

    // R1 stray opcode
    connected = 1;
    issue(8'h17);
    chk("R1 stray busy", busy, 0);
    chk("R1 stray flags", irq_flags, 0);

    // R3 DMA gated
    dma_len = 4;
    issue(8'h15);
    repeat (20) @(negedge clk);
    chk("R3 held busy", busy, 1);
    chk("R3 no req", req_cnt, 0);
    chk("R5 phase io", bus_io, 1);
    issue(8'h16);
    chk("R1 ignored while busy", irq_flags, 0);
    for (int i = 0; i < 4; i++) begin exp_q.push_back(8'hA0 + dma_next); dma_next++; end
    dma_go = 1;
    wait_idle();
    @(negedge clk);
    chk("R4 flags", irq_flags, 3'b011);
    chk("R4 bytes", seen, 4);
    chk("R8 irq dma", irq, 1);
    dma_go = 0;
    clear_all();

    // R6/R7 CPU stall
    cpu_len = 3; seen = 0; req_cnt = 0;
    issue(8'h16);
    repeat (10) @(negedge clk);
    chk("R6 stalled", req_cnt, 0);
    chk("R5 phase before data", {bus_io, bus_cd, bus_msg}, 3'b100);
    push_fifo(8'h11);
    repeat (12) @(negedge clk);
    chk("R6 one byte", seen, 1);
    chk("R6 still busy", busy, 1);
    push_fifo(8'h22);
    push_fifo(8'h33);
    push_fifo(8'h44);
    wait_idle();
    @(negedge clk);
    chk("R7 flags", irq_flags, 3'b001);
    chk("R5 exact count", seen, 3);
    chk("R5 leftover", wr_idx - rd_idx, 1);
    exp_q.delete();
    clear_all();

    // R9 zero length
    req_cnt = 0; dma_len = 0; cpu_len = 0;
    issue(8'h16);
    chk("R9 cpu zero", irq_flags, 3'b001);
    clear_all();
    issue(8'h15);
    chk("R9 dma zero", irq_flags, 3'b011);
    chk("R9 no req", req_cnt, 0);
    chk("R9 idle", busy, 0);
    repeat (3) @(negedge clk);
    chk("R8 sticky", irq_flags, 3'b011);
    finish_run();
  end
endmodule